// File: doc/BRIEF.md
# Inter-Processor Flag and Interrupt Unit

This block carries handshake flags from one processor to another. One instance serves one direction, so two instances give full duplex. The sending processor has three registers: SET, CLEAR and FLAG. Writing ones to SET raises flag bits. Writing ones to CLEAR withdraws them. FLAG shows the current state. The receiving processor has two registers: STATUS, a live copy of the same state, and ACK. Writing ones to ACK retires bits once the matching message has been consumed. The hardware gives no bit a fixed meaning.

The low four flag bits also act as interrupt sources toward the receiver. Each has its own output line. A line pulses for one clock when its flag bit goes from 0 to 1. The upper 28 bits are flags only. Each processor reaches its registers over a simple register bus with address, write enable, write data and combinational read data.

Top module: `ipc_flag_unit`

## Requirements
- R1: After the active-low asynchronous reset, every flag bit, the STATUS value and all four interrupt lines are zero.
- R2: A sender write to offset 0 (SET) sets every flag bit whose write-data bit is 1. Zero bits in the write data leave their flags unchanged. FLAG is read at sender offset 2, and the new value is visible in the cycle after the write edge.
- R3: Reading receiver offset 0 (STATUS) always returns the same value as sender FLAG, in every cycle.
- R4: A receiver write to offset 1 (ACK) clears every flag bit whose write-data bit is 1, in the cycle after the write edge.
- R5: A sender write to offset 1 (CLEAR) clears every flag bit whose write-data bit is 1.
- R6: When a set and a clear (from CLEAR or ACK) hit the same bit in the same cycle, the bit ends up set.
- R7: Interrupt line i (for i from 0 to 3) is high for exactly one cycle: the first cycle in which flag bit i reads 1 after reading 0. Setting a bit that is already 1 gives no pulse.
- R8: Flag bits 31:4 never drive any interrupt line.
- R9: Reads of SET, CLEAR, ACK or any unmapped offset return zero. Writes to unmapped offsets (sender 3, receiver 2 and 3) and writes to STATUS or FLAG change nothing.
- R10: When neither write enable is high, the flags do not change, whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snd_addr_i | input | 2 | Sender register offset |
| snd_we_i | input | 1 | Sender write enable |
| snd_wdata_i | input | 32 | Sender write data |
| snd_rdata_o | output | 32 | Sender read data |
| rcv_addr_i | input | 2 | Receiver register offset |
| rcv_we_i | input | 1 | Receiver write enable |
| rcv_wdata_i | input | 32 | Receiver write data |
| rcv_rdata_o | output | 32 | Receiver read data |
| irq_o | output | 4 | Interrupt pulses toward the receiver |

## Verification
The stimulus table runs these patterns:
- Single-bit and multi-bit sets, including a set of bits that are already 1. This separates a rising-edge pulse from a level-sensitive one.
- Mixed writes that touch bits 31:4 together with low bits. These show that the interrupt lines depend only on the low four bits.
- Same-cycle collisions of SET with ACK, both on a bit that was clear and on a bit that was already set. These confirm that set has priority and that a pulse appears only when the bit was 0 before.
- Zero write data, unmapped offsets and writes to read-only offsets. These must leave the flags as they were.

Directed tests then cover reset, the one-cycle length of each pulse, idle buses carrying stray data, read-back of the write-only offsets, independence of the two duplex copies, and a reset in the middle of a run.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  // sender view offsets
  localparam int unsigned SND_SET_OFS  = 0;
  localparam int unsigned SND_CLR_OFS  = 1;
  localparam int unsigned SND_FLAG_OFS = 2;
  // receiver view offsets
  localparam int unsigned RCV_STAT_OFS = 0;
  localparam int unsigned RCV_ACK_OFS  = 1;
endpackage

// File: rtl/ipc_snd_port.sv
module ipc_snd_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] flag_i,
  output logic [DATA_W-1:0] set_o,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  import ipc_pkg::*;

  logic hit_set, hit_clr, hit_flag;

  assign hit_set  = (addr_i == ADDR_W'(SND_SET_OFS));
  assign hit_clr  = (addr_i == ADDR_W'(SND_CLR_OFS));
  assign hit_flag = (addr_i == ADDR_W'(SND_FLAG_OFS));

  assign set_o   = (we_i && hit_set) ? wdata_i : '0;
  assign clr_o   = (we_i && hit_clr) ? wdata_i : '0;
  assign rdata_o = hit_flag ? flag_i : '0;
endmodule

// File: rtl/ipc_rcv_port.sv
module ipc_rcv_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] flag_i,
  output logic [DATA_W-1:0] ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  import ipc_pkg::*;

  logic hit_stat, hit_ack;

  assign hit_stat = (addr_i == ADDR_W'(RCV_STAT_OFS));
  assign hit_ack  = (addr_i == ADDR_W'(RCV_ACK_OFS));

  assign ack_o   = (we_i && hit_ack) ? wdata_i : '0;
  assign rdata_o = hit_stat ? flag_i : '0;
endmodule

// File: rtl/ipc_flag_core.sv
module ipc_flag_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IRQ_N  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] flag_o,
  output logic [IRQ_N-1:0]  irq_o
);
  logic [DATA_W-1:0] flag_q, flag_d;

  // set has priority over any clear source
  assign flag_d = (flag_q & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  // one flop per interrupt line, pulse on 0->1 of its flag
  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    logic pulse_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= flag_d[i] & ~flag_q[i];
    end
    assign irq_o[i] = pulse_q;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ipc_flag_unit.sv
module ipc_flag_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned IRQ_N  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] snd_addr_i,
  input  logic              snd_we_i,
  input  logic [DATA_W-1:0] snd_wdata_i,
  output logic [DATA_W-1:0] snd_rdata_o,
  input  logic [ADDR_W-1:0] rcv_addr_i,
  input  logic              rcv_we_i,
  input  logic [DATA_W-1:0] rcv_wdata_i,
  output logic [DATA_W-1:0] rcv_rdata_o,
  output logic [IRQ_N-1:0]  irq_o
);
  logic [DATA_W-1:0] flag_q, set_m, clr_m, ack_m;

  ipc_snd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_snd (
    .we_i(snd_we_i), .addr_i(snd_addr_i), .wdata_i(snd_wdata_i),
    .flag_i(flag_q), .set_o(set_m), .clr_o(clr_m), .rdata_o(snd_rdata_o)
  );

  ipc_rcv_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rcv (
    .we_i(rcv_we_i), .addr_i(rcv_addr_i), .wdata_i(rcv_wdata_i),
    .flag_i(flag_q), .ack_o(ack_m), .rdata_o(rcv_rdata_o)
  );

  ipc_flag_core #(.DATA_W(DATA_W), .IRQ_N(IRQ_N)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_m), .clr_i(clr_m | ack_m),
    .flag_o(flag_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/ipc_flag_unit_chk.sv
module ipc_flag_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned IRQ_N  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] snd_addr_i,
  input logic              snd_we_i,
  input logic [DATA_W-1:0] snd_wdata_i,
  input logic [DATA_W-1:0] snd_rdata_o,
  input logic [ADDR_W-1:0] rcv_addr_i,
  input logic              rcv_we_i,
  input logic [DATA_W-1:0] rcv_wdata_i,
  input logic [DATA_W-1:0] rcv_rdata_o,
  input logic [IRQ_N-1:0]  irq_o,
  input logic [DATA_W-1:0] flag_i
);
  logic snd_set_wr, rcv_ack_wr;
  assign snd_set_wr = snd_we_i && (snd_addr_i == ADDR_W'(0));
  assign rcv_ack_wr = rcv_we_i && (rcv_addr_i == ADDR_W'(1));

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> (flag_i == '0 && irq_o == '0));

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_set_wr |=> ((flag_i & $past(snd_wdata_i)) == $past(snd_wdata_i)));

  p_status_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcv_addr_i == ADDR_W'(0)) |-> (rcv_rdata_o == snd_rdata_o || snd_addr_i != ADDR_W'(2)));

  p_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcv_ack_wr && !snd_set_wr) |=> ((flag_i & $past(rcv_wdata_i)) == '0));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcv_ack_wr && snd_set_wr) |=> ((flag_i & $past(snd_wdata_i)) == $past(snd_wdata_i)));

  p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |=> ((irq_o & $past(irq_o)) == '0));

  p_pulse_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> ((irq_o & ~flag_i[IRQ_N-1:0]) == '0));

  p_wo_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_addr_i != ADDR_W'(2)) |-> (snd_rdata_o == '0));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snd_we_i && !rcv_we_i) |=> $stable(flag_i));
endmodule

bind ipc_flag_unit ipc_flag_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_N(IRQ_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .snd_addr_i(snd_addr_i), .snd_we_i(snd_we_i),
  .snd_wdata_i(snd_wdata_i), .snd_rdata_o(snd_rdata_o), .rcv_addr_i(rcv_addr_i),
  .rcv_we_i(rcv_we_i), .rcv_wdata_i(rcv_wdata_i), .rcv_rdata_o(rcv_rdata_o),
  .irq_o(irq_o), .flag_i(flag_q)
);

// File: tb/sim_ipc_flag_unit.sv
`timescale 1ns/1ps
module sim_ipc_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sa, ra, sa1, ra1;
  logic        sw, rw, sw1, rw1;
  logic [31:0] sd, rd, sd1, rd1, srd, rrd, srd1, rrd1;
  logic [3:0]  irq, irq1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipc_flag_unit u0 (.clk_i(clk), .rst_ni(rst_n), .snd_addr_i(sa), .snd_we_i(sw),
    .snd_wdata_i(sd), .snd_rdata_o(srd), .rcv_addr_i(ra), .rcv_we_i(rw),
    .rcv_wdata_i(rd), .rcv_rdata_o(rrd), .irq_o(irq));

  // reverse direction copy
  ipc_flag_unit u1 (.clk_i(clk), .rst_ni(rst_n), .snd_addr_i(sa1), .snd_we_i(sw1),
    .snd_wdata_i(sd1), .snd_rdata_o(srd1), .rcv_addr_i(ra1), .rcv_we_i(rw1),
    .rcv_wdata_i(rd1), .rcv_rdata_o(rrd1), .irq_o(irq1));

  typedef struct packed {
    logic        sw; logic [1:0] sa; logic [31:0] sd;
    logic        rw; logic [1:0] ra; logic [31:0] rd;
    logic [31:0] ef; logic [3:0] ei;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 32'h0000_0001, 1'b0, 2'd1, 32'h0,          32'h0000_0001, 4'h1}, // R2 R7
    '{1'b1, 2'd0, 32'h0000_0003, 1'b0, 2'd1, 32'h0,          32'h0000_0003, 4'h2}, // R7 no repulse
    '{1'b1, 2'd0, 32'h8000_0010, 1'b0, 2'd1, 32'h0,          32'h8000_0013, 4'h0}, // R8
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd1, 32'h0000_0001, 32'h8000_0012, 4'h0}, // R4
    '{1'b1, 2'd1, 32'h8000_0000, 1'b0, 2'd1, 32'h0,          32'h0000_0012, 4'h0}, // R5
    '{1'b1, 2'd0, 32'h0,         1'b0, 2'd1, 32'h0,          32'h0000_0012, 4'h0}, // R2 zero
    '{1'b1, 2'd0, 32'h0000_0004, 1'b1, 2'd1, 32'h0000_0004, 32'h0000_0016, 4'h4}, // R6
    '{1'b1, 2'd0, 32'h0000_0002, 1'b1, 2'd1, 32'h0000_0012, 32'h0000_0006, 4'h0}, // R6
    '{1'b1, 2'd3, 32'h0000_00F0, 1'b0, 2'd1, 32'h0,          32'h0000_0006, 4'h0}, // R9
    '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_0006, 32'h0000_0006, 4'h0}, // R9
    '{1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 2'd1, 32'h0,          32'h0000_0000, 4'h0}, // R5
    '{1'b1, 2'd0, 32'h0000_000F, 1'b0, 2'd1, 32'h0,          32'h0000_000F, 4'hF}, // R7
    '{1'b1, 2'd0, 32'h0000_0008, 1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0000_0008, 4'h0}  // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_read();
    sw = 1'b0; rw = 1'b0; sa = 2'd2; ra = 2'd0; sd = '0; rd = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_read();
    sw1 = 1'b0; rw1 = 1'b0; sa1 = 2'd2; ra1 = 2'd0; sd1 = '0; rd1 = '0;
    #1;
    check("R1 flag at reset", srd, 32'h0);
    check("R1 status at reset", rrd, 32'h0);
    check("R1 irq at reset", {28'h0, irq}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sw = VECS[i].sw; sa = VECS[i].sa; sd = VECS[i].sd;
      rw = VECS[i].rw; ra = VECS[i].ra; rd = VECS[i].rd;
      @(posedge clk);
      #1;
      idle_read();
      #0.5;
      check($sformatf("R2/R4/R5/R6 flag vec %0d", i), srd, VECS[i].ef);
      check($sformatf("R3 status vec %0d", i), rrd, VECS[i].ef);
      check($sformatf("R7/R8 irq vec %0d", i), {28'h0, irq}, {28'h0, VECS[i].ei});
    end

    // R7: pulse lasts one cycle only
    @(negedge clk);
    sw = 1'b1; sa = 2'd0; sd = 32'h0000_0001;
    @(posedge clk); #1; idle_read(); #0.5;
    check("R7 pulse first cycle", {28'h0, irq}, 32'h1);
    @(posedge clk); #1;
    check("R7 pulse second cycle", {28'h0, irq}, 32'h0);
    check("R7 flag held", srd, 32'h0000_0009);

    // R10: stray address/data without write enable
    @(negedge clk);
    sa = 2'd1; sd = 32'hFFFF_FFFF; ra = 2'd1; rd = 32'hFFFF_FFFF;
    @(posedge clk); #1; idle_read(); #0.5;
    check("R10 idle buses", srd, 32'h0000_0009);

    // R9: write-only and unmapped offsets read zero
    sa = 2'd0; #0.5; check("R9 SET reads zero", srd, 32'h0);
    sa = 2'd1; #0.5; check("R9 CLEAR reads zero", srd, 32'h0);
    sa = 2'd3; #0.5; check("R9 sender unmapped", srd, 32'h0);
    ra = 2'd1; #0.5; check("R9 ACK reads zero", rrd, 32'h0);
    ra = 2'd2; #0.5; check("R9 receiver unmapped", rrd, 32'h0);
    idle_read();

    // duplex copies are independent
    #0.5; check("R2 reverse copy untouched", srd1, 32'h0);
    @(negedge clk);
    sw1 = 1'b1; sa1 = 2'd0; sd1 = 32'h0000_0100;
    @(posedge clk); #1; sw1 = 1'b0; sa1 = 2'd2; #0.5;
    check("R2 reverse copy set", srd1, 32'h0000_0100);
    check("R3 reverse copy status", rrd1, 32'h0000_0100);
    check("R8 reverse copy no irq", {28'h0, irq1}, 32'h0);
    check("R2 forward copy unchanged", srd, 32'h0000_0009);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0; #0.5;
    check("R1 async reset flag", srd, 32'h0);
    check("R1 async reset status", rrd1, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule